// File: doc/BRIEF.md
# Burst Address Counter

This block produces the word address that one port of a synchronous dual-port memory uses in each clock cycle. On every rising clock edge it chooses one of four actions. It can force the address to zero, take a new address from the external bus, step its own counter forward by one for burst transfers, or keep the address it already holds. The result sits in an output register and drives the memory array during the cycle after the edge that produced it.

The three controls are active low, and a fixed priority orders them. Clear comes first, then the external load, then the counter step. When none of them is asserted, the address is held. The block has no chip-select or byte-lane input, so it acts on every edge. Software can therefore load a starting address or step a burst while the port is deselected. The address is 15 bits wide by default, which covers a 32K-word array. Stepping past the highest address wraps the counter to zero.

Top module: `bac_burst_addr`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `addr_q` becomes 0 after that edge, whatever the values of `ld_n`, `step_n` and `ext_addr`.
- R2: When `clr_n` is 1 and `ld_n` is 0 at a rising edge, `addr_q` becomes `ext_addr` after that edge, whatever the value of `step_n`.
- R3: When `clr_n` and `ld_n` are 1 and `step_n` is 0 at a rising edge, `addr_q` becomes its previous value plus one.
- R4: When `clr_n`, `ld_n` and `step_n` are all 1 at a rising edge, `addr_q` keeps its value, and `ext_addr` has no effect.
- R5: A step from the highest address (all ones) gives address 0.
- R6: While `rst` is 1 at a rising edge, `addr_q` becomes 0, whatever the other inputs are.
- R7: `addr_q` changes only at a rising edge. Inputs applied between two edges do not appear on `addr_q` before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; all actions take place on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W (15) | External address, taken when a load is selected |
| ld_n | input | 1 | Active-low load of the external address |
| step_n | input | 1 | Active-low counter advance |
| clr_n | input | 1 | Active-low counter clear; has the highest priority |
| addr_q | output | ADDR_W (15) | Registered address used in the current cycle |

## Verification
The risky cases are edges where several controls are asserted at once: clear together with load or step, and load together with step. The bench drives these combinations on purpose. It expects the clear to win over both, and the load to win over the step. In each case the bench also puts an `ext_addr` value on the bus that differs from the expected result, so the wrong winner shows up on `addr_q`. A step from the all-ones address is also checked, and it must give zero.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } bac_op_t;
endpackage

// File: rtl/bac_op_decode.sv
module bac_op_decode
  import bac_pkg::*;
(
  input  logic    ld_n,
  input  logic    step_n,
  input  logic    clr_n,
  output bac_op_t op
);
  // Fixed priority: clear, then load, then step, else hold.
  always_comb begin
    if (!clr_n)       op = OP_CLEAR;
    else if (!ld_n)   op = OP_LOAD;
    else if (!step_n) op = OP_STEP;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/bac_next_addr.sv
module bac_next_addr
  import bac_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  bac_op_t           op,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] ext,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // Natural modulo-2^ADDR_W add gives wrap from all-ones to zero.
  logic [ADDR_W-1:0] inc;
  assign inc = cur + ONE;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = ext;
      OP_STEP:  nxt = inc;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bac_burst_addr.sv
module bac_burst_addr
  import bac_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              ld_n,
  input  logic              step_n,
  input  logic              clr_n,
  output logic [ADDR_W-1:0] addr_q
);
  bac_op_t           op;
  logic [ADDR_W-1:0] nxt;

  bac_op_decode u_dec (
    .ld_n   (ld_n),
    .step_n (step_n),
    .clr_n  (clr_n),
    .op     (op)
  );

  bac_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
    .op  (op),
    .cur (addr_q),
    .ext (ext_addr),
    .nxt (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= nxt;
  end
endmodule

// File: rtl/bac_burst_addr_chk.sv
module bac_burst_addr_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              ld_n,
  input logic              step_n,
  input logic              clr_n,
  input logic [ADDR_W-1:0] addr_q
);
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (addr_q == '0));

  p_load_ext_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !ld_n) |=> (addr_q == $past(ext_addr)));

  p_step_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && !step_n) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && step_n) |=> $stable(addr_q));

  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && !step_n && (&addr_q)) |=> (addr_q == '0));
endmodule

bind bac_burst_addr bac_burst_addr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ext_addr (ext_addr),
  .ld_n     (ld_n),
  .step_n   (step_n),
  .clr_n    (clr_n),
  .addr_q   (addr_q)
);

// File: tb/bac_burst_addr_test.sv
module bac_burst_addr_test;
  localparam int AW = 15;

  typedef struct {
    logic [AW-1:0] val;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          ld_n = 1'b1;
  logic          step_n = 1'b1;
  logic          clr_n = 1'b1;
  logic [AW-1:0] addr_q;

  int   n_chk = 0;
  int   n_err = 0;
  exp_t sb[$];
  logic [AW-1:0] model = '0;

  always #4 clk = ~clk;

  bac_burst_addr #(.ADDR_W(AW)) uut (
    .clk      (clk),
    .rst      (rst),
    .ext_addr (ext_addr),
    .ld_n     (ld_n),
    .step_n   (step_n),
    .clr_n    (clr_n),
    .addr_q   (addr_q)
  );

  // Driver: applies one cycle of stimulus at the falling edge and queues
  // the value addr_q must show after the following rising edge.
  task automatic cyc(input logic r, input logic c, input logic l,
                     input logic s, input logic [AW-1:0] e, input string tag);
    exp_t x;
    @(negedge clk);
    rst = r; clr_n = c; ld_n = l; step_n = s; ext_addr = e;
    if (r)       model = '0;
    else if (!c) model = '0;
    else if (!l) model = e;
    else if (!s) model = model + 1'b1;
    x.val = model;
    x.tag = tag;
    sb.push_back(x);
  endtask

  // Monitor: samples shortly after each rising edge.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      n_chk++;
      if (addr_q !== x.val) begin
        n_err++;
        $display("FAIL %s: addr_q=%h expected=%h", x.tag, addr_q, x.val);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    cyc(1, 1, 1, 1, 15'h0000, "R6 reset");
    cyc(1, 1, 0, 0, 15'h5555, "R6 reset beats load");
    cyc(0, 1, 0, 1, 15'h1234, "R2 load");
    // R7: a new load between edges must not reach addr_q before the edge.
    @(negedge clk);
    ld_n = 1'b0; ext_addr = 15'h0ABC;
    #1;
    n_chk++;
    if (addr_q !== 15'h1234) begin
      n_err++;
      $display("FAIL R7 no change between edges: addr_q=%h expected=%h", addr_q, 15'h1234);
    end
    ld_n = 1'b1;
    cyc(0, 1, 1, 0, 15'h7777, "R3 step");
    cyc(0, 1, 1, 0, 15'h0000, "R3 step");
    cyc(0, 1, 1, 0, 15'h0001, "R3 step");
    cyc(0, 1, 1, 1, 15'h2222, "R4 hold ignores ext");
    cyc(0, 1, 1, 1, 15'h7FFF, "R4 hold ignores ext");
    cyc(0, 0, 0, 0, 15'h3333, "R1 clear beats load and step");
    cyc(0, 1, 0, 0, 15'h4444, "R2 load beats step");
    cyc(0, 1, 0, 1, 15'h7FFE, "R2 load near top");
    cyc(0, 1, 1, 0, 15'h0000, "R3 step to top");
    cyc(0, 1, 1, 0, 15'h1111, "R5 wrap to zero");
    cyc(0, 1, 1, 0, 15'h0000, "R3 step after wrap");
    cyc(0, 0, 1, 0, 15'h6666, "R1 clear beats step");
    cyc(0, 1, 1, 0, 15'h0000, "R3 step after clear");
    cyc(0, 1, 1, 1, 15'h0F0F, "R4 hold");
    cyc(1, 1, 1, 0, 15'h0000, "R6 reset beats step");
    cyc(0, 1, 1, 1, 15'h0000, "R4 hold after reset");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule